// File: doc/BRIEF.md
# Multi-Channel Prescaled Down-Counter Timer Unit

This block is a memory-mapped timer peripheral on an APB slave port. One shared prescaler divides the bus clock into a common tick. A parameterised bank of one to seven down-counting channels each count that tick. Each channel counts from its reload value to zero and signals an underflow on the tick after zero. On underflow the channel either stops (one-shot) or reloads itself and keeps running. Software can force a load of the counter from the reload register. A channel can also be chained so that it counts the underflows of the channel below it instead of the shared tick.

Each channel has a pending flag that is set on underflow and cleared by writing one to it. The flag becomes an interrupt only when the channel's interrupt-enable bit is set. A build parameter selects one interrupt line per channel or a single shared line. A read-only configuration word reports how the unit was built, so that software can discover the channel count, the interrupt numbering and the interrupt mode.

Top module: `ptimer_unit`

## Requirements
- R1: After reset, every scaler, counter, reload and control register reads 0 and all interrupt outputs are low.
- R2: Offset 0x08 is read-only. It reads the channel count in bits 2:0, the base interrupt number in bits 7:3, the separate-interrupt flag in bit 8, 1 in bit 9 (freeze is disabled because there is no halt input), and 0 in all other bits.
- R3: The scaler value at offset 0x00 counts down by one every clock. When it is 0 it produces one tick and reloads from the scaler reload register at 0x04. Ticks are therefore exactly (scaler_reload+1) clocks apart.
- R4: An enabled channel with the restart bit set (control bit 1) reloads its counter from its reload register on underflow and keeps running. Underflows are exactly (reload+1) decrement events apart.
- R5: An enabled channel with restart clear counts down to 0, and on its next decrement event it underflows. It then clears its enable bit (control bit 0), and its counter stays at 0.
- R6: Writing 1 to the load bit (control bit 2) copies the reload register into the counter. The load bit always reads 0, and so does the unimplemented halt bit (bit 6).
- R7: The reload and counter registers are CNT_W bits wide. Bits above that width read 0, so writing all ones and then loading presets the counter to 2^CNT_W-1.
- R8: The pending bit (control bit 4) is set on underflow. Writing 1 to it clears it and writing 0 leaves it unchanged. An underflow in the same cycle as a clear leaves it set.
- R9: A channel's interrupt is its pending bit ANDed with its interrupt-enable bit (control bit 3). In separate mode, channel n drives irq_o[n]. In shared mode, irq_o[0] is the OR of all channels.
- R10: With the chain bit (control bit 5) set, channel n>0 decrements on each underflow of channel n-1 and ignores the tick. On channel 0 the chain bit has no effect.
- R11: Channel n occupies offsets 0x10+16n, with the counter at +0 (writable), reload at +4 and control at +8. Offsets that map to nothing read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| irq_o | output | NCH or 1 | Interrupt lines, one per channel in separate mode |

## Verification
The bench measures the spacing of interrupt rises in clocks, so a prescaler that is off by one, or a channel period of reload instead of reload+1, shows up as a wrong interval. It drives a chained pair with the lower channel stopped. A chain that still takes the shared tick, or that honours the chain bit on channel 0, would move the counter or change the period. It probes the pending bit with write-zero, write-one and interrupt-enable off. A level-cleared flag or an ungated interrupt would then show the wrong flag or a live line. Wide writes to the reload register catch upper bits that are not masked.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
  // control word bit positions (software decodes these)
  localparam int CB_EN = 0;
  localparam int CB_RS = 1;
  localparam int CB_LD = 2;
  localparam int CB_IE = 3;
  localparam int CB_IP = 4;
  localparam int CB_CH = 5;

  // register offsets inside a 16-byte window
  localparam logic [3:0] OFS_A = 4'h0;
  localparam logic [3:0] OFS_B = 4'h4;
  localparam logic [3:0] OFS_C = 4'h8;
endpackage

// File: rtl/ptu_prescaler.sv
module ptu_prescaler #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_val,
  input  logic          wr_rld,
  input  logic [31:0]   wdata,
  output logic [SW-1:0] val,
  output logic [SW-1:0] rld,
  output logic          tick
);
  logic [SW-1:0] val_nx, rld_nx;

  assign tick = (val == '0) && !wr_val;

  always_comb begin
    rld_nx = rld;
    val_nx = val;
    if (wr_rld) rld_nx = wdata[SW-1:0];
    if (wr_val)           val_nx = wdata[SW-1:0];
    else if (val == '0)   val_nx = rld;
    else                  val_nx = val - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val <= '0;
      rld <= '0;
    end else begin
      val <= val_nx;
      rld <= rld_nx;
    end
  end
endmodule

// File: rtl/ptu_channel.sv
module ptu_channel
  import ptu_pkg::*;
#(
  parameter int CW  = 16,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          prev_uf,
  input  logic          wr_cnt,
  input  logic          wr_rld,
  input  logic          wr_ctl,
  input  logic [31:0]   wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] rld,
  output logic [6:0]    ctl,
  output logic          uf,
  output logic          irq,
  output logic          en_q,
  output logic          rs_q,
  output logic          ip_q
);
  logic ie_q, ch_q;
  logic [CW-1:0] cnt_nx, rld_nx;
  logic en_nx, rs_nx, ie_nx, ip_nx, ch_nx;
  logic step, chain_eff, clr_ip;

  generate
    if (IDX == 0) begin : g_head
      assign chain_eff = 1'b0;
    end else begin : g_link
      assign chain_eff = ch_q;
    end
  endgenerate

  assign step   = en_q && (chain_eff ? prev_uf : tick);
  assign uf     = step && (cnt == '0);
  assign clr_ip = wr_ctl && wdata[CB_IP];
  assign irq    = ip_q && ie_q;
  assign ctl    = {1'b0, ch_q, ip_q, ie_q, 1'b0, rs_q, en_q};

  always_comb begin
    cnt_nx = cnt;
    rld_nx = rld;
    en_nx  = en_q;
    rs_nx  = rs_q;
    ie_nx  = ie_q;
    ch_nx  = ch_q;
    // counting
    if (uf) begin
      if (rs_q) cnt_nx = rld;
      else      en_nx  = 1'b0;
    end else if (step) begin
      cnt_nx = cnt - 1'b1;
    end
    // bus writes override counting
    if (wr_rld) rld_nx = wdata[CW-1:0];
    if (wr_cnt) cnt_nx = wdata[CW-1:0];
    if (wr_ctl) begin
      en_nx = wdata[CB_EN];
      rs_nx = wdata[CB_RS];
      ie_nx = wdata[CB_IE];
      ch_nx = wdata[CB_CH];
      if (wdata[CB_LD]) cnt_nx = rld;
    end
    ip_nx = (ip_q && !clr_ip) || uf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      rld  <= '0;
      en_q <= 1'b0;
      rs_q <= 1'b0;
      ie_q <= 1'b0;
      ip_q <= 1'b0;
      ch_q <= 1'b0;
    end else begin
      cnt  <= cnt_nx;
      rld  <= rld_nx;
      en_q <= en_nx;
      rs_q <= rs_nx;
      ie_q <= ie_nx;
      ip_q <= ip_nx;
      ch_q <= ch_nx;
    end
  end
endmodule

// File: rtl/ptimer_unit.sv
module ptimer_unit
  import ptu_pkg::*;
#(
  parameter int NCH      = 3,
  parameter int CNT_W    = 16,
  parameter int SCL_W    = 16,
  parameter int SEP_IRQ  = 1,
  parameter int IRQ_BASE = 5
) (
  input  logic                           pclk,
  input  logic                           presetn,
  input  logic                           psel,
  input  logic                           penable,
  input  logic                           pwrite,
  input  logic [7:0]                     paddr,
  input  logic [31:0]                    pwdata,
  output logic [31:0]                    prdata,
  output logic [(SEP_IRQ!=0?NCH:1)-1:0]  irq_o
);
  localparam logic [31:0] CFG_WORD = {22'd0, 1'b1, (SEP_IRQ != 0),
                                      5'(IRQ_BASE), 3'(NCH)};

  logic             bus_we, bus_re, base_win;
  logic             tick;
  logic [SCL_W-1:0] scl_val, scl_rld;
  logic [NCH-1:0]   uf_v, irq_v, en_v, rs_v, ip_v, wctl_v, wcnt_v, wrld_v;
  logic [CNT_W-1:0] cnt_a [NCH];
  logic [CNT_W-1:0] rld_a [NCH];
  logic [6:0]       ctl_a [NCH];
  logic [31:0]      rdata;

  assign bus_we   = psel && penable && pwrite;
  assign bus_re   = psel && !pwrite;
  assign base_win = (paddr[7:4] == 4'h0);

  ptu_prescaler #(.SW(SCL_W)) u_pre (
    .clk    (pclk),
    .rst_n  (presetn),
    .wr_val (bus_we && base_win && paddr[3:0] == OFS_A),
    .wr_rld (bus_we && base_win && paddr[3:0] == OFS_B),
    .wdata  (pwdata),
    .val    (scl_val),
    .rld    (scl_rld),
    .tick   (tick)
  );

  genvar n;
  generate
    for (n = 0; n < NCH; n++) begin : g_ch
      logic hit, prev;
      assign hit       = (paddr[7:4] == 4'(n + 1));
      assign wcnt_v[n] = bus_we && hit && paddr[3:0] == OFS_A;
      assign wrld_v[n] = bus_we && hit && paddr[3:0] == OFS_B;
      assign wctl_v[n] = bus_we && hit && paddr[3:0] == OFS_C;
      if (n == 0) begin : g_p0
        assign prev = 1'b0;
      end else begin : g_pn
        assign prev = uf_v[n-1];
      end
      ptu_channel #(.CW(CNT_W), .IDX(n)) u_ch (
        .clk     (pclk),
        .rst_n   (presetn),
        .tick    (tick),
        .prev_uf (prev),
        .wr_cnt  (wcnt_v[n]),
        .wr_rld  (wrld_v[n]),
        .wr_ctl  (wctl_v[n]),
        .wdata   (pwdata),
        .cnt     (cnt_a[n]),
        .rld     (rld_a[n]),
        .ctl     (ctl_a[n]),
        .uf      (uf_v[n]),
        .irq     (irq_v[n]),
        .en_q    (en_v[n]),
        .rs_q    (rs_v[n]),
        .ip_q    (ip_v[n])
      );
    end

    if (SEP_IRQ != 0) begin : g_sep
      assign irq_o = irq_v;
    end else begin : g_shr
      assign irq_o = |irq_v;
    end
  endgenerate

  always_comb begin
    rdata = '0;
    if (base_win) begin
      case (paddr[3:0])
        OFS_A:   rdata = 32'(scl_val);
        OFS_B:   rdata = 32'(scl_rld);
        OFS_C:   rdata = CFG_WORD;
        default: rdata = '0;
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      if (paddr[7:4] == 4'(i + 1)) begin
        case (paddr[3:0])
          OFS_A:   rdata = 32'(cnt_a[i]);
          OFS_B:   rdata = 32'(rld_a[i]);
          OFS_C:   rdata = 32'(ctl_a[i]);
          default: rdata = '0;
        endcase
      end
    end
  end

  assign prdata = bus_re ? rdata : '0;
endmodule

// File: rtl/ptimer_unit_chk.sv
module ptimer_unit_chk #(
  parameter int NCH      = 3,
  parameter int SCL_W    = 16,
  parameter int SEP_IRQ  = 1,
  parameter int IRQ_BASE = 5
) (
  input logic             pclk,
  input logic             presetn,
  input logic             psel,
  input logic             penable,
  input logic             pwrite,
  input logic [7:0]       paddr,
  input logic [31:0]      prdata,
  input logic             tick,
  input logic [SCL_W-1:0] scl_rld,
  input logic [NCH-1:0]   uf_v,
  input logic [NCH-1:0]   en_v,
  input logic [NCH-1:0]   rs_v,
  input logic [NCH-1:0]   ip_v,
  input logic [NCH-1:0]   wctl_v,
  input logic [NCH-1:0]   irq_any
);
  // R3
  tick_gap_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (tick && scl_rld != '0 && !(psel && penable && pwrite)) |=> !tick);

  // R2
  cfg_word_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && paddr == 8'h08) |->
      (prdata == {22'd0, 1'b1, (SEP_IRQ != 0), 5'(IRQ_BASE), 3'(NCH)}));

  // R6
  ld_reads_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (psel && !pwrite && paddr[7:4] != 4'h0 && paddr[3:0] == 4'h8) |->
      (prdata[2] == 1'b0 && prdata[6] == 1'b0));

  // R9
  irq_needs_pend_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (|irq_any) |-> (|ip_v));

  genvar n;
  generate
    for (n = 0; n < NCH; n++) begin : g_c
      // R8
      pend_set_chk: assert property (@(posedge pclk) disable iff (!presetn)
        uf_v[n] |=> ip_v[n]);
      // R5
      oneshot_stop_chk: assert property (@(posedge pclk) disable iff (!presetn)
        (uf_v[n] && !rs_v[n] && !wctl_v[n]) |=> !en_v[n]);
    end
  endgenerate
endmodule

bind ptimer_unit ptimer_unit_chk #(
  .NCH(NCH), .SCL_W(SCL_W), .SEP_IRQ(SEP_IRQ), .IRQ_BASE(IRQ_BASE)
) u_chk (
  .pclk    (pclk),
  .presetn (presetn),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .prdata  (prdata),
  .tick    (tick),
  .scl_rld (scl_rld),
  .uf_v    (uf_v),
  .en_v    (en_v),
  .rs_v    (rs_v),
  .ip_v    (ip_v),
  .wctl_v  (wctl_v),
  .irq_any (irq_v)
);

// File: tb/sim_ptimer_unit.sv
`timescale 1ns/1ps
module sim_ptimer_unit;
  localparam int NCH = 3;
  localparam logic [31:0] EN = 1, RS = 2, LD = 4, IE = 8, IP = 16, CH = 32;

  logic        pclk, presetn, psel, penable, pwrite;
  logic [7:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic [NCH-1:0] irq_o;
  int checks, errors, cyc;
  bit done;

  ptimer_unit #(.NCH(NCH), .CNT_W(16), .SCL_W(16), .SEP_IRQ(1), .IRQ_BASE(5)) u0 (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .irq_o(irq_o));

  initial pclk = 1'b0;
  always #2.5 pclk = ~pclk;
  always @(posedge pclk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge pclk);
    penable = 1;
    @(negedge pclk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge pclk);
    psel = 1; pwrite = 0; paddr = a;
    #1 d = prdata;
    psel = 0;
  endtask

  function automatic logic [7:0] ca(input int ch, input int o);
    return 8'(16 + 16 * ch + o);
  endfunction

  task automatic wait_irq(input int i, output int t);
    t = -1;
    for (int k = 0; k < 3000; k++) begin
      @(negedge pclk);
      if (irq_o[i]) begin t = cyc; break; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq", 32'(irq_o), 0);
    rd(8'h00, d); chk("R1 scaler", d, 0);
    rd(ca(0,8), d); chk("R1 ctl0", d, 0);
    rd(ca(2,0), d); chk("R1 cnt2", d, 0);
    rd(8'h08, d); chk("R2 cfg", d, 32'd811);
    rd(8'h0C, d); chk("R11 unmapped read", d, 0);
  endtask

  task automatic t_width_load();
    logic [31:0] d;
    wr(8'h04, 32'd1000);
    wr(ca(0,4), 32'hFFFF_FFFF);
    rd(ca(0,4), d); chk("R7 reload width", d, 32'h0000_FFFF);
    wr(ca(0,8), LD);
    rd(ca(0,0), d); chk("R6 load preset max", d, 32'h0000_FFFF);
    rd(ca(0,8), d); chk("R6 ld reads 0", d, 0);
    wr(ca(0,8), 32'h40);
    rd(ca(0,8), d); chk("R6 halt bit reads 0", d, 0);
    wr(ca(2,0), 32'h1234);
    rd(ca(2,0), d); chk("R11 counter write", d, 32'h1234);
    wr(8'h70, 32'h55);
    rd(8'h70, d); chk("R11 absent channel", d, 0);
    rd(ca(2,0), d); chk("R11 no alias", d, 32'h1234);
  endtask

  task automatic t_oneshot();
    logic [31:0] d;
    wr(8'h04, 0); wr(8'h00, 0);
    wr(ca(2,4), 3);
    wr(ca(2,8), LD | EN | IE);
    repeat (20) @(negedge pclk);
    rd(ca(2,8), d); chk("R5 R8 oneshot ctl", d, IE | IP);
    rd(ca(2,0), d); chk("R5 counter held 0", d, 0);
    chk("R9 irq2 high", 32'(irq_o[2]), 1);
    wr(ca(2,8), IE);
    rd(ca(2,8), d); chk("R8 write 0 keeps pend", d, IE | IP);
    wr(ca(2,8), IE | IP);
    rd(ca(2,8), d); chk("R8 w1c", d, IE);
    chk("R9 irq2 low", 32'(irq_o[2]), 0);
    wr(ca(1,4), 2);
    wr(ca(1,8), LD | EN);
    repeat (20) @(negedge pclk);
    rd(ca(1,8), d); chk("R9 pend without ie", d, IP);
    chk("R9 irq1 gated", 32'(irq_o[1]), 0);
  endtask

  task automatic t_period();
    logic [31:0] d;
    int t1, t2;
    wr(8'h04, 3);
    wr(ca(0,4), 4);
    wr(ca(0,8), LD | EN | RS | IE | IP);
    rd(8'h00, d); chk("R3 scaler in range", 32'(d <= 3), 1);
    wait_irq(0, t1); wr(ca(0,8), EN | RS | IE | IP);
    wait_irq(0, t2); wr(ca(0,8), EN | RS | IE | IP);
    chk("R3 R4 period clocks", 32'(t2 - t1), 20);
    wr(ca(0,8), EN | RS | IE | IP | CH);
    wait_irq(0, t1); wr(ca(0,8), EN | RS | IE | IP | CH);
    wait_irq(0, t2); wr(ca(0,8), EN | RS | IE | IP | CH);
    chk("R10 chain ignored on ch0", 32'(t2 - t1), 20);
    rd(ca(0,8), d); chk("R4 still running", d & EN, EN);
  endtask

  task automatic t_chain();
    logic [31:0] d;
    int t1, t2;
    wr(ca(0,8), IP);
    wr(ca(1,4), 2);
    wr(ca(1,8), LD | EN | RS | IE | IP | CH);
    repeat (40) @(negedge pclk);
    rd(ca(1,0), d); chk("R10 chained idle", d, 2);
    wr(ca(0,4), 1);
    wr(ca(0,8), LD | EN | RS);
    wait_irq(1, t1); wr(ca(1,8), EN | RS | IE | IP | CH);
    wait_irq(1, t2); wr(ca(1,8), EN | RS | IE | IP | CH);
    chk("R10 chained period", 32'(t2 - t1), 24);
  endtask

  initial begin
    checks = 0; errors = 0; cyc = 0; done = 0;
    psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    presetn = 0;
    repeat (4) @(negedge pclk);
    presetn = 1;
    t_reset();
    t_width_load();
    t_oneshot();
    t_period();
    t_chain();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge pclk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule